// File: doc/BRIEF.md
# Register-mapped I2C bus master

This block is a single-master I2C controller that software drives through four byte-wide registers: a divider index, a control byte, a status byte and a data byte. Software enables the module, then sets the master bit to seize the bus with a START condition. A write to the data register in transmit direction sends one byte. A read of the data register in receive direction clocks in the next byte and answers it with ACK or NACK, as chosen beforehand in the control byte. Clearing the master bit releases the bus with a STOP condition. A set pulse on the repeated-start control bit re-addresses the bus without giving it up. Each byte ends with a byte-done flag, which can also raise an interrupt.

The bus side is open drain. The block only ever pulls SCL or SDA low through active-high output enables, and it reads the wire levels back. Each bit period is split into four equal quarters of system clocks, and the length of one quarter follows from a 6-bit coded divider index. The bus-busy status bit comes from watching the wires for START and STOP conditions, not from the internal sequencer.

Top module: `i2c_reg_master`

## Requirements
- R1: After reset, control (address 1) reads 0x00 and status (address 2) reads 0x80. Both line enables and the interrupt are low. Register addresses are: 0 divider index, 1 control, 2 status, 3 data.
- R2: Control bits are 7 enable, 6 interrupt enable, 5 master, 4 transmit, 3 no-acknowledge and 2 repeated start. A write that takes master from 0 to 1 with enable set makes SDA fall while SCL is high. Status bit 5 (bus busy) then reads 1.
- R3: A write that takes master from 1 to 0 with enable still set makes SDA rise while SCL is high. Status bit 5 then returns to 0.
- R4: A control write with master already 1 and bit 2 set produces a new SDA fall while SCL is high, and bus busy stays 1 throughout. Bit 2 always reads back as 0.
- R5: In transmit direction with master set, a data-register write shifts the byte out MSB first over nine SCL pulses. Status bit 1 (byte done) then sets. Status bit 0 takes the SDA level seen on the ninth pulse, where 1 means NACK.
- R6: Status bit 7 reads 0 while a byte is being clocked and 1 once it is finished.
- R7: In receive direction with master set, a data-register read starts the next byte. That read returns the previous byte. The received byte is assembled MSB first. On the ninth pulse the block pulls SDA low (ACK) when control bit 3 is 0, and leaves it released (NACK) when bit 3 is 1.
- R8: If master is cleared before the last received byte is read, a later data-register read returns that byte and produces no SCL pulses.
- R9: The SCL period in system clocks is the ratio chosen by the divider index, rounded down to a multiple of 4. Index 0x20 gives 20, index 0x00 gives 28 and index 0x3F gives 2048. An index with no listed ratio, such as 0x01, falls back to 3840.
- R10: Divider writes made while the module is enabled are ignored. The register keeps its old value and the SCL period does not change.
- R11: Writing a control value with bit 7 clear disables and resets the module. Both line enables are released and status returns to 0x80, even in the middle of a byte.
- R12: The interrupt output is high exactly when interrupt enable and byte done are both set. A status write with bit 1 clear clears byte done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register select |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe; only the data register has a read side effect |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt request |
| sclIn | input | 1 | SCL wire level |
| sdaIn | input | 1 | SDA wire level |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaOe | output | 1 | Pull SDA low when 1 |

## Verification
The bench aims at the points where the register side effects meet the bus. These are the dummy read that must start the first receive byte, the ACK or NACK chosen before a read, and a STOP placed ahead of the final read. A design that clocked on that final read would show extra SCL pulses after STOP. A design that latched the acknowledge choice late would ACK the byte it should refuse. The bench also measures SCL periods for a listed index, for a second listed index, for an unlisted index and after a divider write made while enabled. An off-by-one quarter count, a wrong table entry or a divider that follows live writes each changes a measured gap. A disable in the middle of a byte must release both wires at once. A repeated START must never let bus busy drop.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int RATIO_W = 12;
  localparam logic [1:0] ADR_DIV = 2'd0, ADR_CTRL = 2'd1, ADR_STAT = 2'd2, ADR_DATA = 2'd3;
  localparam int B_EN = 7, B_IRQ = 6, B_MST = 5, B_TX = 4, B_NOACK = 3, B_RST = 2;

  typedef struct packed {
    logic       start;
    logic       restart;
    logic       stop;
    logic       byteGo;
    logic       txDir;
    logic       noAck;
    logic [7:0] txByte;
  } engCmd_t;

  typedef struct packed {
    logic       ready;
    logic       inByte;
    logic       byteDone;
    logic       ackIn;
    logic       busBusy;
    logic [7:0] rxByte;
  } engStat_t;

  function automatic logic [RATIO_W-1:0] ratioOf(input logic [5:0] idx);
    case (idx)
      6'h20: ratioOf = 22;   6'h21: ratioOf = 24;   6'h22: ratioOf = 26;   6'h23: ratioOf = 28;
      6'h24: ratioOf = 32;   6'h25: ratioOf = 36;   6'h26: ratioOf = 40;   6'h27: ratioOf = 44;
      6'h28: ratioOf = 48;   6'h29: ratioOf = 56;   6'h2A: ratioOf = 64;   6'h2B: ratioOf = 72;
      6'h2C: ratioOf = 80;   6'h2D: ratioOf = 96;   6'h2E: ratioOf = 112;  6'h2F: ratioOf = 128;
      6'h30: ratioOf = 160;  6'h31: ratioOf = 192;  6'h32: ratioOf = 224;  6'h33: ratioOf = 256;
      6'h34: ratioOf = 320;  6'h35: ratioOf = 384;  6'h36: ratioOf = 448;  6'h37: ratioOf = 512;
      6'h38: ratioOf = 640;  6'h39: ratioOf = 768;  6'h3A: ratioOf = 896;  6'h3B: ratioOf = 1024;
      6'h3C: ratioOf = 1280; 6'h3D: ratioOf = 1536; 6'h3E: ratioOf = 1792; 6'h3F: ratioOf = 2048;
      6'h00: ratioOf = 30;   6'h03: ratioOf = 42;   6'h05: ratioOf = 52;   6'h06: ratioOf = 60;
      6'h09: ratioOf = 88;   6'h0A: ratioOf = 104;  6'h0C: ratioOf = 144;  6'h0F: ratioOf = 240;
      6'h10: ratioOf = 288;  6'h13: ratioOf = 480;  6'h14: ratioOf = 576;  6'h17: ratioOf = 960;
      6'h18: ratioOf = 1152; 6'h1B: ratioOf = 1920; 6'h1C: ratioOf = 2304; 6'h1D: ratioOf = 2560;
      6'h1E: ratioOf = 3072;
      default: ratioOf = 3840;
    endcase
  endfunction
endpackage

// File: rtl/i2cm_engine.sv
module i2cm_engine import i2cm_pkg::*; #(
  parameter int RW = RATIO_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enIn,
  input  engCmd_t       cmd,
  input  logic [RW-1:0] ratio,
  input  logic          sclIn,
  input  logic          sdaIn,
  output engStat_t      stat,
  output logic          sclLow,
  output logic          sdaLow
);
  localparam int QW = RW - 2;
  typedef enum logic [2:0] {E_IDLE, E_HOLD, E_START, E_RESTART, E_STOP, E_BYTE} eState_t;

  eState_t       state;
  logic [1:0]    phase;
  logic [3:0]    bitIdx;
  logic [7:0]    shiftR;
  logic [QW-1:0] cnt, quarter;
  logic          isTx, noAckR, doneR, ackR, busyR, sclQ, sdaQ;
  logic          ready, tick, go, bitDrive;

  assign quarter = QW'(ratio >> 2);
  assign ready   = (state == E_IDLE) || (state == E_HOLD);
  assign tick    = (cnt == '0);
  assign go      = cmd.start | cmd.restart | cmd.stop | cmd.byteGo;

  always_comb begin
    if (bitIdx < 4'd8) bitDrive = isTx ? ~shiftR[7] : 1'b0;
    else               bitDrive = isTx ? 1'b0 : ~noAckR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= E_IDLE; phase <= '0; bitIdx <= '0; shiftR <= '0; cnt <= '0;
      isTx <= 1'b0; noAckR <= 1'b0; doneR <= 1'b0; ackR <= 1'b0;
      sclLow <= 1'b0; sdaLow <= 1'b0;
    end else if (!enIn) begin
      state <= E_IDLE; phase <= '0; cnt <= '0; doneR <= 1'b0;
      sclLow <= 1'b0; sdaLow <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (ready) begin
        if (go) begin
          cnt <= quarter - 1'b1; phase <= '0; bitIdx <= '0;
          if (cmd.start)        state <= E_START;
          else if (cmd.restart) state <= E_RESTART;
          else if (cmd.stop)    state <= E_STOP;
          else begin
            state <= E_BYTE; shiftR <= cmd.txByte; isTx <= cmd.txDir; noAckR <= cmd.noAck;
          end
        end
      end else begin
        cnt <= tick ? quarter - 1'b1 : cnt - 1'b1;
        if (tick) begin
          phase <= phase + 1'b1;
          case (state)
            E_START: begin
              if (phase == 2'd0) sdaLow <= 1'b1;
              else begin sclLow <= 1'b1; state <= E_HOLD; end
            end
            E_RESTART: begin
              case (phase)
                2'd0: sdaLow <= 1'b0;
                2'd1: sclLow <= 1'b0;
                2'd2: sdaLow <= 1'b1;
                default: begin sclLow <= 1'b1; state <= E_HOLD; end
              endcase
            end
            E_STOP: begin
              case (phase)
                2'd0: sdaLow <= 1'b1;
                2'd1: sclLow <= 1'b0;
                default: begin sdaLow <= 1'b0; state <= E_IDLE; end
              endcase
            end
            E_BYTE: begin
              case (phase)
                2'd0: sdaLow <= bitDrive;
                2'd1: sclLow <= 1'b0;
                2'd2: if (bitIdx < 4'd8) shiftR <= {shiftR[6:0], sdaIn};
                      else ackR <= sdaIn;
                default: begin
                  sclLow <= 1'b1;
                  if (bitIdx == 4'd8) begin state <= E_HOLD; doneR <= 1'b1; end
                  else bitIdx <= bitIdx + 1'b1;
                end
              endcase
            end
            default: state <= state;
          endcase
        end
      end
    end
  end

  // Bus-busy follows START/STOP conditions seen on the wires
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1; sdaQ <= 1'b1; busyR <= 1'b0;
    end else begin
      sclQ <= sclIn; sdaQ <= sdaIn;
      if (!enIn) busyR <= 1'b0;
      else if (sclQ && sclIn && sdaQ && !sdaIn) busyR <= 1'b1;
      else if (sclQ && sclIn && !sdaQ && sdaIn) busyR <= 1'b0;
    end
  end

  assign stat.ready    = ready;
  assign stat.inByte   = (state == E_BYTE);
  assign stat.byteDone = doneR;
  assign stat.ackIn    = ackR;
  assign stat.busBusy  = busyR;
  assign stat.rxByte   = shiftR;

  // Checker counter: SCL releases seen during one byte
  logic [3:0] relCnt;
  logic       sclLowQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relCnt <= '0; sclLowQ <= 1'b0;
    end else begin
      sclLowQ <= sclLow;
      if (ready && cmd.byteGo) relCnt <= '0;
      else if (state == E_BYTE && sclLowQ && !sclLow && relCnt != 4'hF) relCnt <= relCnt + 1'b1;
    end
  end

  a_r5_nine_clocks: assert property (@(posedge clk) disable iff (!rstN)
    doneR |-> relCnt == 4'd9);

  a_r5_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    (state == E_BYTE && $past(state == E_BYTE) && !sclLow && $past(!sclLow))
      |-> sdaLow == $past(sdaLow));

  a_r11_disable_releases: assert property (@(posedge clk) disable iff (!rstN)
    !enIn |=> (!sclLow && !sdaLow));
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs import i2cm_pkg::*; #(
  parameter int RW = RATIO_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    regAddr,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [7:0]    wrData,
  output logic [7:0]    rdData,
  output logic          irq,
  input  engStat_t      stat,
  output engCmd_t       cmd,
  output logic          enOut,
  output logic [RW-1:0] ratio
);
  logic [5:0] divIdx;
  logic [7:0] dataR;
  logic       en, irqEn, master, txDir, noAck, byteFlag, nackR;
  logic       wrDiv, wrCtrl, wrStat, wrDat, rdDat;

  assign wrDiv  = wrEn && regAddr == ADR_DIV;
  assign wrCtrl = wrEn && regAddr == ADR_CTRL;
  assign wrStat = wrEn && regAddr == ADR_STAT;
  assign wrDat  = wrEn && regAddr == ADR_DATA;
  assign rdDat  = rdEn && regAddr == ADR_DATA;

  always_comb begin
    cmd        = '0;
    cmd.txByte = wrData;
    cmd.txDir  = txDir;
    cmd.noAck  = noAck;
    if (stat.ready) begin
      cmd.start   = wrCtrl && wrData[B_EN] && wrData[B_MST] && !master;
      cmd.stop    = wrCtrl && wrData[B_EN] && !wrData[B_MST] && master;
      cmd.restart = wrCtrl && wrData[B_EN] && wrData[B_MST] && wrData[B_RST] && master;
      cmd.byteGo  = en && master && ((wrDat && txDir) || (rdDat && !txDir));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divIdx <= '0; dataR <= '0; en <= 1'b0; irqEn <= 1'b0; master <= 1'b0;
      txDir <= 1'b0; noAck <= 1'b0; byteFlag <= 1'b0; nackR <= 1'b0;
    end else begin
      if (wrDiv && !en) divIdx <= wrData[5:0];
      if (wrCtrl) begin
        en <= wrData[B_EN]; irqEn <= wrData[B_IRQ]; master <= wrData[B_MST];
        txDir <= wrData[B_TX]; noAck <= wrData[B_NOACK];
      end
      if (stat.byteDone) byteFlag <= 1'b1;
      else if ((wrCtrl && !wrData[B_EN]) || (wrStat && !wrData[1])) byteFlag <= 1'b0;
      if (stat.byteDone && txDir) nackR <= stat.ackIn;
      else if (wrCtrl && !wrData[B_EN]) nackR <= 1'b0;
      if (stat.byteDone && !txDir) dataR <= stat.rxByte;
      else if (wrDat) dataR <= wrData;
    end
  end

  always_comb begin
    case (regAddr)
      ADR_DIV:  rdData = {2'b00, divIdx};
      ADR_CTRL: rdData = {en, irqEn, master, txDir, noAck, 3'b000};
      ADR_STAT: rdData = {~stat.inByte, 1'b0, stat.busBusy, 3'b000, byteFlag, nackR};
      default:  rdData = dataR;
    endcase
  end

  assign irq   = irqEn & byteFlag;
  assign enOut = en;
  assign ratio = RW'(ratioOf(divIdx));

  a_r5_done_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    stat.byteDone |=> byteFlag);
endmodule

// File: rtl/i2c_reg_master.sv
module i2c_reg_master import i2cm_pkg::*; #(
  parameter int RW = RATIO_W
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regAddr,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       irq,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe
);
  engCmd_t       cmd;
  engStat_t      stat;
  logic          en;
  logic [RW-1:0] ratio;

  i2cm_regs #(.RW(RW)) i_regs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .irq(irq), .stat(stat), .cmd(cmd),
    .enOut(en), .ratio(ratio)
  );

  i2cm_engine #(.RW(RW)) i_engine (
    .clk(clk), .rstN(rstN), .enIn(en), .cmd(cmd), .ratio(ratio),
    .sclIn(sclIn), .sdaIn(sdaIn), .stat(stat), .sclLow(sclOe), .sdaLow(sdaOe)
  );
endmodule

// File: tb/test_i2c_reg_master.sv
`timescale 1ns/1ps
module test_i2c_reg_master;
  logic       clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] wrData = 8'h00, rdData;
  logic       irq, sclOe, sdaOe;
  int nChk = 0, nBad = 0;
  bit finished = 1'b0;

  // Bus and slave model
  logic       slvMode = 1'b0, slvAck = 1'b1, slvQuiet = 1'b0, sNinth = 1'b1;
  logic [7:0] slvByte = 8'h00, sRecv = 8'h00, sLast = 8'h00;
  logic [3:0] sBits = 4'd0, sIdx = 4'd0;
  logic       prevScl = 1'b1, prevSda = 1'b1;
  int         startCnt = 0, stopCnt = 0, riseCnt = 0;
  longint     cyc = 0, lastRise = 0, prevRise = 0;

  function automatic logic slvDrive(input logic [3:0] idx);
    if (slvQuiet) return 1'b0;
    if (idx < 4'd8) return slvMode && !slvByte[3'(4'd7 - idx)];
    return !slvMode && slvAck;
  endfunction

  wire sclBus = ~sclOe;
  wire sdaBus = ~(sdaOe | slvDrive(sIdx));

  i2c_reg_master i_i2c_reg_master (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .irq(irq), .sclIn(sclBus), .sdaIn(sdaBus),
    .sclOe(sclOe), .sdaOe(sdaOe)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(sclBus or sdaBus) begin
    if (sclBus && prevScl && prevSda && !sdaBus) begin
      startCnt++; sBits = 0; sIdx = 0; slvQuiet = 1'b0;
    end else if (sclBus && prevScl && !prevSda && sdaBus) begin
      stopCnt++;
    end else if (sclBus && !prevScl) begin
      riseCnt++; prevRise = lastRise; lastRise = cyc;
      if (sBits < 4'd8) sRecv = {sRecv[6:0], sdaBus};
      else begin
        sNinth = sdaBus; sLast = sRecv;
        if (slvMode && sdaBus) slvQuiet = 1'b1;
      end
      sBits = (sBits == 4'd8) ? 4'd0 : sBits + 4'd1;
    end else if (!sclBus && prevScl) begin
      sIdx = sBits;
    end
    prevScl = sclBus; prevSda = sdaBus;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk); regAddr = a; wrData = v; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); regAddr = a; rdEn = 1'b1; #1 v = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic waitByte(input string tag, input int limit);
    bit seen = 1'b0;
    for (int i = 0; i < limit && !seen; i++) begin
      @(negedge clk); regAddr = 2'd2; #1 seen = rdData[1];
    end
    chk({tag, " byte done"}, 32'(seen), 32'd1);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd1, v); chk("R1 ctrl", 32'(v), 32'h00);
    rd(2'd2, v); chk("R1 status", 32'(v), 32'h80);
    chk("R1 lines", 32'({sclOe, sdaOe, irq}), 32'd0);
  endtask

  task automatic t_write_path();
    logic [7:0] v;
    int s;
    s = startCnt;
    wr(2'd0, 8'h20); wr(2'd1, 8'h80); wr(2'd1, 8'hB0);
    repeat (40) @(negedge clk);
    chk("R2 start seen", 32'(startCnt), 32'(s + 1));
    rd(2'd2, v); chk("R2 busy", 32'(v[5]), 32'd1);
    slvMode = 1'b0; slvAck = 1'b1;
    wr(2'd3, 8'hA5);
    repeat (8) @(negedge clk);
    rd(2'd2, v); chk("R6 in flight", 32'(v[7]), 32'd0);
    waitByte("R5", 400);
    rd(2'd2, v); chk("R5 R6 status after byte", 32'(v), 32'hA2);
    chk("R5 byte on wire", 32'(sLast), 32'hA5);
    chk("R5 ack seen", 32'(sNinth), 32'd0);
    chk("R9 period idx 0x20", 32'(lastRise - prevRise), 32'd20);
    chk("R12 irq masked", 32'(irq), 32'd0);
    wr(2'd1, 8'hF0);
    chk("R12 irq raised", 32'(irq), 32'd1);
    wr(2'd2, 8'h00);
    chk("R12 irq cleared", 32'(irq), 32'd0);
    rd(2'd2, v); chk("R12 flag cleared", 32'(v[1]), 32'd0);
    wr(2'd1, 8'hB0);
  endtask

  task automatic t_nack();
    logic [7:0] v;
    slvAck = 1'b0;
    wr(2'd3, 8'h3C);
    waitByte("R5 nack", 400);
    rd(2'd2, v); chk("R5 nack status", 32'(v), 32'hA3);
    chk("R5 nack byte", 32'(sLast), 32'h3C);
    wr(2'd2, 8'h00);
    slvAck = 1'b1;
  endtask

  task automatic t_restart_read();
    logic [7:0] v;
    int s, r;
    s = startCnt;
    wr(2'd1, 8'hB4);
    repeat (40) @(negedge clk);
    chk("R4 restart seen", 32'(startCnt), 32'(s + 1));
    rd(2'd2, v); chk("R4 busy held", 32'(v[5]), 32'd1);
    rd(2'd1, v); chk("R4 bit2 reads 0", 32'(v), 32'hB0);
    wr(2'd3, 8'h91);
    waitByte("R4", 400);
    chk("R4 address byte", 32'(sLast), 32'h91);
    wr(2'd2, 8'h00);
    slvByte = 8'h5E; slvMode = 1'b1;
    wr(2'd1, 8'hA0);
    rd(2'd3, v);
    waitByte("R7 first", 400);
    chk("R7 master ack", 32'(sNinth), 32'd0);
    wr(2'd2, 8'h00);
    slvByte = 8'hC3;
    wr(2'd1, 8'hA8);
    rd(2'd3, v); chk("R7 first data", 32'(v), 32'h5E);
    waitByte("R7 second", 400);
    chk("R7 master nack", 32'(sNinth), 32'd1);
    wr(2'd2, 8'h00);
    s = stopCnt;
    wr(2'd1, 8'h88);
    repeat (40) @(negedge clk);
    chk("R3 stop seen", 32'(stopCnt), 32'(s + 1));
    rd(2'd2, v); chk("R3 bus idle status", 32'(v), 32'h80);
    r = riseCnt;
    rd(2'd3, v); chk("R8 last data", 32'(v), 32'hC3);
    repeat (200) @(negedge clk);
    chk("R8 no extra clocks", 32'(riseCnt), 32'(r));
    slvMode = 1'b0;
  endtask

  task automatic t_divider();
    logic [7:0] v;
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R11 ctrl cleared", 32'(v), 32'h00);
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk("R9 index stored", 32'(v), 32'h00);
    wr(2'd1, 8'h80); wr(2'd1, 8'hB0);
    repeat (60) @(negedge clk);
    wr(2'd0, 8'h3F);
    rd(2'd0, v); chk("R10 write ignored", 32'(v), 32'h00);
    wr(2'd3, 8'h5A);
    waitByte("R10", 600);
    chk("R9 R10 period idx 0x00", 32'(lastRise - prevRise), 32'd28);
    chk("R10 byte", 32'(sLast), 32'h5A);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'hFF);
    repeat (30) @(negedge clk);
    wr(2'd1, 8'h00);
    @(negedge clk);
    chk("R11 lines released", 32'({sclOe, sdaOe}), 32'd0);
    rd(2'd2, v); chk("R11 status reset", 32'(v), 32'h80);
    rd(2'd1, v); chk("R11 ctrl zero", 32'(v), 32'h00);
  endtask

  task automatic t_unlisted();
    logic [7:0] v;
    wr(2'd0, 8'h01); wr(2'd1, 8'h80); wr(2'd1, 8'hB0);
    repeat (2100) @(negedge clk);
    wr(2'd3, 8'h42);
    waitByte("R9 unlisted", 40000);
    chk("R9 period unlisted", 32'(lastRise - prevRise), 32'd3840);
    chk("R9 unlisted byte", 32'(sLast), 32'h42);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h80);
    repeat (3000) @(negedge clk);
    rd(2'd2, v); chk("R3 idle after slow stop", 32'(v[5]), 32'd0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write_path();
    t_nack();
    t_restart_read();
    t_divider();
    t_unlisted();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
  end
endmodule